// File: doc/BRIEF.md
# Field-Masked Processor Status Register

This block holds the status word of a processor core together with a banked copy of it. The banked copy is the word that exception entry saves and exception return restores. Software reads either word through a combinational read port. It updates either word through a write port. A write carries a data word, taken from a general register value or from an immediate, and a four-bit field mask. Each mask bit enables one byte of the 32-bit word.

The byte fields are fixed by bit position:

| Mask bit | Bits | Field |
|---|---|---|
| 0 | 7:0 | control |
| 1 | 15:8 | extension |
| 2 | 23:16 | status |
| 3 | 31:24 | condition flags |

The control byte holds the mode field, the state bit and the two interrupt masks. These are also driven out to the rest of the core as dedicated signals.

Privilege is tracked as a two-state machine decoded from the live mode field:

- **PRIV_USER**: the mode field equals 5'b10000. A write may touch only the flags byte, and the other mask bits are dropped.
- **PRIV_ELEVATED**: any other mode code. All four mask bits are honoured.

The machine has two transitions:

- **ELEVATED to USER** is taken when an elevated write places 5'b10000 into the control byte.
- **USER to ELEVATED** cannot be made by a write, because the control byte is locked in user mode. It is reached only through reset.

A separate direct-load input lets the exception logic replace the banked copy in one cycle.

Top module: `status_reg_unit`

## Requirements
- R1: While reset is asserted and after its release, the live word reads 32'h0000_00D3 (elevated mode 5'b10011, both interrupt masks set, state bit clear) and the banked word reads 32'h0000_0000.
- R2: A write replaces exactly those bytes whose mask bit is set: mask bit i selects bits 8i+7:8i. All other bits keep their value.
- R3: When wr_from_imm is 1 the write data is wr_imm_data, otherwise wr_reg_data.
- R4: wr_banked=0 directs a write to the live word and wr_banked=1 to the banked word. The word not selected is unchanged.
- R5: When the live mode field (bits 4:0) is 5'b10000, only mask bit 3 (bits 31:24) takes effect, for either target. Mask bits 0 to 2 are ignored.
- R6: rd_value shows the word chosen by rd_banked in the same cycle. A write becomes visible only after the next rising clock edge. With no write and no load both words hold.
- R7: irq_masked is live bit 7, fiq_masked is live bit 6, state_bit is live bit 5 and mode_field is live bits 4:0.
- R8: bank_load_en=1 loads bank_load_data into the banked word at the next edge. It overrides a write to the banked word in the same cycle, and it does not block a write to the live word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_banked | input | 1 | Read select: 0 live word, 1 banked word |
| rd_value | output | 32 | Selected word, combinational |
| wr_en | input | 1 | Write request |
| wr_banked | input | 1 | Write target: 0 live word, 1 banked word |
| wr_from_imm | input | 1 | Write source: 1 immediate, 0 register value |
| wr_reg_data | input | 32 | Register-sourced write data |
| wr_imm_data | input | 32 | Immediate write data |
| wr_field_mask | input | 4 | Byte enables: bit 0 control through bit 3 flags |
| bank_load_en | input | 1 | Direct load of the banked word |
| bank_load_data | input | 32 | Value for the direct load |
| irq_masked | output | 1 | Live IRQ mask bit |
| fiq_masked | output | 1 | Live FIQ mask bit |
| state_bit | output | 1 | Live instruction-set state bit |
| mode_field | output | 5 | Live mode field |

## Verification
The bench sweeps all sixteen masks against both targets and both data sources, once in elevated mode and once after dropping to user mode. It recomputes every byte arithmetically.

A mask decoded to the wrong byte lane, or a source mux reversed, shows up as a corrupted neighbour byte. A user-mode gate that leaks mask bits lets the control byte change and the mode escape. A target select that also touches the other word corrupts the untouched copy.

Simultaneous direct load and banked write expose a wrong priority. Reading back before the edge catches a write that lands a cycle early.

// File: rtl/status_reg_pkg.sv
package status_reg_pkg;
    // privilege state decoded from the live mode field
    typedef enum logic {
        PRIV_USER     = 1'b0,
        PRIV_ELEVATED = 1'b1
    } priv_e;
endpackage

// File: rtl/status_mask_gate.sv
module status_mask_gate
    import status_reg_pkg::*;
#(
    parameter int NUM_FIELDS = 4
) (
    input  priv_e                 priv,
    input  logic [NUM_FIELDS-1:0] req_mask,
    output logic [NUM_FIELDS-1:0] eff_mask
);
    localparam int FLAGS_IDX = NUM_FIELDS - 1;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_lane
        if (i == FLAGS_IDX) begin : g_open
            assign eff_mask[i] = req_mask[i];
        end else begin : g_guarded
            assign eff_mask[i] = req_mask[i] & (priv == PRIV_ELEVATED);
        end
    end

    // R5
    always_comb begin
        if (priv == PRIV_USER) begin
            user_lanes_closed_chk: assert (eff_mask[FLAGS_IDX-1:0] == '0);
        end
    end
endmodule

// File: rtl/status_byte_merge.sv
module status_byte_merge #(
    parameter int WORD_W  = 32,
    parameter int FIELD_W = 8
) (
    input  logic [WORD_W-1:0]         old_word,
    input  logic [WORD_W-1:0]         src_word,
    input  logic [WORD_W/FIELD_W-1:0] lane_en,
    output logic [WORD_W-1:0]         merged
);
    localparam int LANES = WORD_W / FIELD_W;

    for (genvar i = 0; i < LANES; i++) begin : g_byte
        assign merged[i*FIELD_W +: FIELD_W] =
            lane_en[i] ? src_word[i*FIELD_W +: FIELD_W]
                       : old_word[i*FIELD_W +: FIELD_W];
    end
endmodule

// File: rtl/status_reg_unit.sv
module status_reg_unit
    import status_reg_pkg::*;
#(
    parameter int              SR_W        = 32,
    parameter int              FIELD_W     = 8,
    parameter int              MODE_W      = 5,
    parameter logic [MODE_W-1:0] USER_CODE = 5'b10000,
    parameter logic [SR_W-1:0] LIVE_RESET  = 32'h0000_00D3,
    parameter logic [SR_W-1:0] BANK_RESET  = 32'h0000_0000,
    parameter int              IRQ_POS     = 7,
    parameter int              FIQ_POS     = 6,
    parameter int              STATE_POS   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_banked,
    output logic [SR_W-1:0]           rd_value,
    input  logic                      wr_en,
    input  logic                      wr_banked,
    input  logic                      wr_from_imm,
    input  logic [SR_W-1:0]           wr_reg_data,
    input  logic [SR_W-1:0]           wr_imm_data,
    input  logic [SR_W/FIELD_W-1:0]   wr_field_mask,
    input  logic                      bank_load_en,
    input  logic [SR_W-1:0]           bank_load_data,
    output logic                      irq_masked,
    output logic                      fiq_masked,
    output logic                      state_bit,
    output logic [MODE_W-1:0]         mode_field
);
    localparam int NUM_FIELDS = SR_W / FIELD_W;

    logic [SR_W-1:0]       live_q, bank_q;
    logic [SR_W-1:0]       src_word, live_merged, bank_merged;
    logic [NUM_FIELDS-1:0] eff_mask;
    logic                  live_we, bank_we;
    priv_e                 priv_now;

    // privilege state decode (transitions happen through live_q updates)
    always_comb begin
        unique case (live_q[MODE_W-1:0])
            USER_CODE: priv_now = PRIV_USER;
            default:   priv_now = PRIV_ELEVATED;
        endcase
    end

    assign src_word = wr_from_imm ? wr_imm_data : wr_reg_data;
    assign live_we  = wr_en & ~wr_banked;
    assign bank_we  = wr_en &  wr_banked;

    status_mask_gate #(.NUM_FIELDS(NUM_FIELDS)) u_gate (
        .priv     (priv_now),
        .req_mask (wr_field_mask),
        .eff_mask (eff_mask)
    );

    status_byte_merge #(.WORD_W(SR_W), .FIELD_W(FIELD_W)) u_live_merge (
        .old_word (live_q),
        .src_word (src_word),
        .lane_en  (eff_mask),
        .merged   (live_merged)
    );

    status_byte_merge #(.WORD_W(SR_W), .FIELD_W(FIELD_W)) u_bank_merge (
        .old_word (bank_q),
        .src_word (src_word),
        .lane_en  (eff_mask),
        .merged   (bank_merged)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= LIVE_RESET;
            bank_q <= BANK_RESET;
        end else begin
            if (live_we) live_q <= live_merged;
            if (bank_load_en)  bank_q <= bank_load_data;
            else if (bank_we)  bank_q <= bank_merged;
        end
    end

    always_comb begin
        rd_value   = rd_banked ? bank_q : live_q;
        irq_masked = live_q[IRQ_POS];
        fiq_masked = live_q[FIQ_POS];
        state_bit  = live_q[STATE_POS];
        mode_field = live_q[MODE_W-1:0];
    end

    // R2
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_lane_chk
        lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (live_we && !eff_mask[i]) |=> $stable(live_q[i*FIELD_W +: FIELD_W]));
        lane_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (live_we && eff_mask[i]) |=>
                live_q[i*FIELD_W +: FIELD_W] == $past(src_word[i*FIELD_W +: FIELD_W]));
    end

    // R4
    bank_write_spares_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> $stable(live_q));

    // R5
    user_control_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_now == PRIV_USER) |=> $stable(live_q[SR_W-FIELD_W-1:0]));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !bank_load_en) |=> ($stable(live_q) && $stable(bank_q)));

    // R8
    bank_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_load_en |=> bank_q == $past(bank_load_data));
endmodule

// File: tb/status_reg_unit_bench.sv
module status_reg_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_banked;
    logic [31:0] rd_value;
    logic        wr_en, wr_banked, wr_from_imm;
    logic [31:0] wr_reg_data, wr_imm_data;
    logic [3:0]  wr_field_mask;
    logic        bank_load_en;
    logic [31:0] bank_load_data;
    logic        irq_masked, fiq_masked, state_bit;
    logic [4:0]  mode_field;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    logic [31:0] exp_live, exp_bank, rng;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_reg_unit u_status_reg_unit (
        .clk(clk), .rst_n(rst_n), .rd_banked(rd_banked), .rd_value(rd_value),
        .wr_en(wr_en), .wr_banked(wr_banked), .wr_from_imm(wr_from_imm),
        .wr_reg_data(wr_reg_data), .wr_imm_data(wr_imm_data),
        .wr_field_mask(wr_field_mask), .bank_load_en(bank_load_en),
        .bank_load_data(bank_load_data), .irq_masked(irq_masked),
        .fiq_masked(fiq_masked), .state_bit(state_bit), .mode_field(mode_field)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        rd_banked = 1'b0; #1;
        chk({tag, " live"}, rd_value, exp_live);
        rd_banked = 1'b1; #1;
        chk({tag, " banked"}, rd_value, exp_bank);
        // R7 control byte outputs
        chk("R7 outputs", {24'd0, irq_masked, fiq_masked, state_bit, mode_field},
            {24'd0, exp_live[7:0]});
    endtask

    task automatic apply(input string tag, input bit tgt, input bit imm,
                         input logic [3:0] m, input logic [31:0] d,
                         input bit ld, input logic [31:0] ldd);
        logic [3:0]  eff;
        logic [31:0] bm;
        @(negedge clk);
        wr_en = 1'b1; wr_banked = tgt; wr_from_imm = imm;
        wr_reg_data = imm ? ~d : d;
        wr_imm_data = imm ? d : ~d;
        wr_field_mask = m;
        bank_load_en = ld; bank_load_data = ldd;
        rd_banked = tgt; #1;
        chk("R6 same-cycle", rd_value, tgt ? exp_bank : exp_live);
        eff = (exp_live[4:0] == 5'b10000) ? (m & 4'b1000) : m;
        bm = {{8{eff[3]}}, {8{eff[2]}}, {8{eff[1]}}, {8{eff[0]}}};
        if (!tgt) exp_live = (exp_live & ~bm) | (d & bm);
        if (ld) exp_bank = ldd;
        else if (tgt) exp_bank = (exp_bank & ~bm) | (d & bm);
        @(negedge clk);
        wr_en = 1'b0; bank_load_en = 1'b0;
        check_all(tag);
    endtask

    initial begin
        rst_n = 1'b0; rd_banked = 1'b0; wr_en = 1'b0; wr_banked = 1'b0;
        wr_from_imm = 1'b0; wr_reg_data = '0; wr_imm_data = '0;
        wr_field_mask = '0; bank_load_en = 1'b0; bank_load_data = '0;
        rng = 32'h1234_5678;
        exp_live = 32'h0000_00D3; exp_bank = 32'h0;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R2 R3 R4 elevated sweep, mode kept at 5'b11111
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 2; s++)
                for (int m = 0; m < 16; m++) begin
                    rng = next_rand(rng);
                    apply("R2 R3 R4 elevated", t[0], s[0], m[3:0],
                          {rng[31:5], 5'b11111}, 1'b0, 32'h0);
                end

        // R6 idle hold
        @(negedge clk); @(negedge clk);
        check_all("R6 idle");

        // R8 load against banked write, then alongside live write
        apply("R8 load over banked write", 1'b1, 1'b0, 4'hF, 32'hAAAA_5555, 1'b1, 32'hC0DE_F00D);
        apply("R8 load with live write", 1'b0, 1'b1, 4'b0110, 32'h0BAD_CAFF, 1'b1, 32'h1357_9BDF);

        // R5 enter user mode, then sweep
        apply("R5 enter user", 1'b0, 1'b0, 4'b0001, 32'h0000_0090, 1'b0, 32'h0);
        chk("R5 mode user", {27'd0, mode_field}, 32'h10);
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 2; s++)
                for (int m = 0; m < 16; m++) begin
                    rng = next_rand(rng);
                    apply("R5 user", t[0], s[0], m[3:0], rng, 1'b0, 32'h0);
                end

        // R1 reset returns to elevated
        @(negedge clk);
        rst_n = 1'b0;
        exp_live = 32'h0000_00D3; exp_bank = 32'h0;
        @(negedge clk);
        check_all("R1 re-reset");
        rst_n = 1'b1;
        apply("R2 after re-reset", 1'b0, 1'b1, 4'b0001, 32'h0000_001F, 1'b0, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule